// File: doc/BRIEF.md
# Gated Two-Stage Card Clock Divider

This block turns one fast input clock into two clock-enable pulse trains for a storage-card interface. One control register sets the rate and the gating. A source stage divides by 1, 2, 4, 8 or 16. An output stage then divides that result again by 2 or 4. The product of the two stages sets the total division, from 2 to 64.

The main card enable `cardClkEn` pulses once per total period. The high-speed companion enable `hsClkEn` pulses once per source-stage period. Each output has its own stop bit. A status output shows whether both clocks are running.

Software sets the whole configuration in one register write. A write that holds an illegal code is dropped entirely and raises an error flag. A new divider setting only takes over once the current main period has finished, so a rate change never produces a short period.

Top module: `sd_clk_gate_div`

## Requirements
- R1: After reset, `rdData` reads 0x301 (both stop bits set, source code 0, output code 1). `running` and `errFlag` are 0, and neither enable output pulses.
- R2: Register layout is fixed:
  - bit 9 stops the companion output;
  - bit 8 stops the main output;
  - bits 7:5 are reserved and read as 0;
  - bits 4:2 are the source code, where code k divides by 2^k for k = 0..4;
  - bits 1:0 are the output code, where 0 divides by 2 and 1 divides by 4.
- R3: While bit 8 is clear, `cardClkEn` is high for exactly one cycle in every S*O cycles. S is the source factor and O is the output factor of the active setting. The pulse falls on the last cycle of each period.
- R4: While bit 9 is clear, `hsClkEn` is high for one cycle in every S cycles, aligned to the ends of the source periods. With S = 1 it is high on every cycle.
- R5: `running` is 1 exactly when both stop bits in the register are 0.
- R6: A legal write replaces all register fields at once, so stop bits and divider codes change together. It also clears `errFlag`.
- R7: A write is illegal if any of these hold:
  - the source code is 5 to 7;
  - the output code is 2 or 3;
  - any reserved bit 7:5 is 1.
  An illegal write leaves the whole register unchanged and sets `errFlag`. The flag stays set until the next legal write.
- R8: A newly written divider setting becomes active only at the end of the current main period. The period in progress keeps its old length.
- R9: A stop-bit change takes effect on the cycle after the write. From then on the affected enable output stays low, and it resumes on the active schedule once the bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 10 | Register write value |
| rdData | output | 10 | Register read value |
| running | output | 1 | High when both outputs are ungated |
| errFlag | output | 1 | Last write held an illegal encoding |
| cardClkEn | output | 1 | Main card clock enable pulse |
| hsClkEn | output | 1 | Companion high-speed clock enable pulse |

## Verification
The bench writes new divider settings in the middle of a main period. A design that switched at once would emit a shortened period there, which the per-cycle model catches on the pulse positions. Illegal source codes, illegal output codes and set reserved bits are each written separately. A design that updated a partial field, or failed to hold the error flag until a legal write, would show the wrong read value or flag. Stop bits are toggled on their own and together at several rates, including the divide-by-one source stage, where the companion enable must be high on every cycle.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
  localparam int REG_W        = 10;
  localparam int SRC_W        = 3;
  localparam int OUT_W        = 2;
  localparam int SRC_MAX_CODE = 4;
  localparam int OUT_MAX_CODE = 1;
  localparam int HS_STOP_BIT  = 9;
  localparam int MN_STOP_BIT  = 8;
  localparam int CNT_W        = SRC_MAX_CODE + OUT_MAX_CODE + 1;
  localparam logic [REG_W-1:0] RESET_VAL = 10'h301;

  typedef struct packed {
    logic             stopHs;
    logic             stopMain;
    logic [SRC_W-1:0] srcCode;
    logic [OUT_W-1:0] outCode;
  } divCfg_t;
endpackage

// File: rtl/sdclk_ctrl.sv
module sdclk_ctrl
  import sdclk_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output divCfg_t          cfg,
  output logic [REG_W-1:0] rdData,
  output logic             running,
  output logic             errFlag
);
  logic [SRC_W-1:0] wSrc;
  logic [OUT_W-1:0] wOut;
  logic [2:0]       wRsv;
  logic             illegal;

  assign wSrc = wrData[SRC_W+OUT_W-1:OUT_W];
  assign wOut = wrData[OUT_W-1:0];
  assign wRsv = wrData[MN_STOP_BIT-1:SRC_W+OUT_W];
  assign illegal = (wSrc > SRC_W'(SRC_MAX_CODE)) || (wOut > OUT_W'(OUT_MAX_CODE)) || (wRsv != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg.stopHs   <= RESET_VAL[HS_STOP_BIT];
      cfg.stopMain <= RESET_VAL[MN_STOP_BIT];
      cfg.srcCode  <= RESET_VAL[SRC_W+OUT_W-1:OUT_W];
      cfg.outCode  <= RESET_VAL[OUT_W-1:0];
      errFlag      <= 1'b0;
    end else if (wrEn) begin
      if (illegal) begin
        errFlag <= 1'b1;
      end else begin
        cfg.stopHs   <= wrData[HS_STOP_BIT];
        cfg.stopMain <= wrData[MN_STOP_BIT];
        cfg.srcCode  <= wSrc;
        cfg.outCode  <= wOut;
        errFlag      <= 1'b0;
      end
    end
  end

  assign rdData  = {cfg.stopHs, cfg.stopMain, 3'b000, cfg.srcCode, cfg.outCode};
  assign running = !cfg.stopHs && !cfg.stopMain;

  // R7: illegal write holds register and raises the flag
  a_r7_illegal_hold: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && illegal) |=> (errFlag && $stable(rdData)));
  // R6: legal write lands in full and clears the flag
  a_r6_legal_load: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !illegal) |=> (!errFlag && rdData == ($past(wrData) & 10'h31F)));
endmodule

// File: rtl/sdclk_datapath.sv
module sdclk_datapath
  import sdclk_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  divCfg_t cfg,
  output logic    cardClkEn,
  output logic    hsClkEn
);
  logic [CNT_W-1:0] cnt;
  logic [SRC_W-1:0] actSrc;
  logic [OUT_W-1:0] actOut;
  logic [CNT_W:0]   periodLim;
  logic [CNT_W:0]   srcMask;
  logic             boundary;
  logic             srcTick;

  assign periodLim = ((CNT_W+1)'(1) << (actSrc + SRC_W'(actOut) + SRC_W'(1))) - (CNT_W+1)'(1);
  assign srcMask   = ((CNT_W+1)'(1) << actSrc) - (CNT_W+1)'(1);
  assign boundary  = ({1'b0, cnt} == periodLim);
  assign srcTick   = (({1'b0, cnt} & srcMask) == srcMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      actSrc <= RESET_VAL[SRC_W+OUT_W-1:OUT_W];
      actOut <= RESET_VAL[OUT_W-1:0];
    end else if (boundary) begin
      cnt    <= '0;
      actSrc <= cfg.srcCode;
      actOut <= cfg.outCode;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  assign cardClkEn = boundary && !cfg.stopMain;
  assign hsClkEn   = srcTick && !cfg.stopHs;

  // R8: active setting only moves at a period end
  a_r8_boundary_only: assert property (@(posedge clk) disable iff (!rstN)
    !boundary |=> ($stable(actSrc) && $stable(actOut)));
  // R3: main pulses never on consecutive cycles
  a_r3_no_short_pulse: assert property (@(posedge clk) disable iff (!rstN)
    cardClkEn |=> !cardClkEn);
  // R4: every main period end is also a source period end
  a_r4_nested_ticks: assert property (@(posedge clk) disable iff (!rstN)
    boundary |-> srcTick);
endmodule

// File: rtl/sd_clk_gate_div.sv
module sd_clk_gate_div
  import sdclk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [9:0]  wrData,
  output logic [9:0]  rdData,
  output logic        running,
  output logic        errFlag,
  output logic        cardClkEn,
  output logic        hsClkEn
);
  divCfg_t cfg;

  sdclk_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .cfg(cfg), .rdData(rdData), .running(running), .errFlag(errFlag)
  );

  sdclk_datapath u_dp (
    .clk(clk), .rstN(rstN), .cfg(cfg),
    .cardClkEn(cardClkEn), .hsClkEn(hsClkEn)
  );

  // R9: a set stop bit silences its output
  a_r9_main_gated: assert property (@(posedge clk) disable iff (!rstN)
    rdData[MN_STOP_BIT] |-> !cardClkEn);
  a_r9_hs_gated: assert property (@(posedge clk) disable iff (!rstN)
    rdData[HS_STOP_BIT] |-> !hsClkEn);
  // R5: status tracks register stop bits
  a_r5_running: assert property (@(posedge clk) disable iff (!rstN)
    running |-> (rdData[9:8] == 2'b00));
endmodule

// File: tb/sd_clk_gate_div_bench.sv
module sd_clk_gate_div_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [9:0] wrData = '0;
  logic [9:0] rdData;
  logic running, errFlag, cardClkEn, hsClkEn;

  int nChecks = 0;
  int nFails = 0;
  bit cmpOn = 0;

  // model state
  int mReg = 'h301;
  int mErr = 0;
  int mCnt = 0;
  int mActSrc = 0;
  int mActOut = 1;

  always #5 clk = ~clk;

  sd_clk_gate_div u_sd_clk_gate_div (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .running(running), .errFlag(errFlag),
    .cardClkEn(cardClkEn), .hsClkEn(hsClkEn)
  );

  function automatic bit legalVal(int v);
    return ((v >> 2) & 7) <= 4 && (v & 3) <= 1 && ((v >> 5) & 7) == 0;
  endfunction

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mReg = 'h301; mErr = 0; mCnt = 0; mActSrc = 0; mActOut = 1;
    end else begin
      int n;
      n = (1 << mActSrc) * (2 << mActOut);
      if (mCnt == n - 1) begin
        mCnt = 0;
        mActSrc = (mReg >> 2) & 7;
        mActOut = mReg & 3;
      end else begin
        mCnt++;
      end
      if (wrEn) begin
        if (legalVal(int'(wrData))) begin
          mReg = int'(wrData) & 'h31F;
          mErr = 0;
        end else begin
          mErr = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (cmpOn) begin
      int n, sf;
      n  = (1 << mActSrc) * (2 << mActOut);
      sf = 1 << mActSrc;
      check("R2/R6/R7 rdData", int'(rdData), mReg);
      check("R7 errFlag", int'(errFlag), mErr);
      check("R5 running", int'(running), int'(((mReg >> 8) & 3) == 0));
      check("R3/R8/R9 cardClkEn", int'(cardClkEn),
            int'(mCnt == n - 1 && ((mReg >> 8) & 1) == 0));
      check("R4/R9 hsClkEn", int'(hsClkEn),
            int'((mCnt % sf) == sf - 1 && ((mReg >> 9) & 1) == 0));
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(int v);
    wrEn = 1'b1; wrData = 10'(v);
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  initial begin
    fork
      begin
        #1_000_000;
        nFails++; nChecks++;
        $display("FAIL watchdog expired");
      end
      begin
        idle(3);
        // R1 reset state while held in reset
        check("R1 rdData", int'(rdData), 'h301);
        check("R1 running", int'(running), 0);
        check("R1 errFlag", int'(errFlag), 0);
        check("R1 cardClkEn", int'(cardClkEn), 0);
        rstN = 1'b1;
        cmpOn = 1;
        idle(10);
        wr('h000);          // R6 run both, /1 x /2
        idle(21);
        wr('h20D);          // R8 mid-period switch to /8 x /4, hs stopped
        idle(75);
        wr('h014);          // R7 source code 5
        idle(4);
        wr('h002);          // R7 output code 2
        idle(3);
        wr('h0A0);          // R7 reserved bit set
        idle(5);
        wr('h10D);          // R9 stop main only
        idle(40);
        wr('h010);          // /16 x /2
        idle(90);
        wr('h011);          // /16 x /4 = 64
        wr('h00C);          // back-to-back write, /8 x /2
        idle(150);
        wr('h005);          // /2 x /4
        idle(30);
        wr('h300);          // R9 stop both
        idle(12);
        wr('h001);          // /1 x /4
        idle(20);
        cmpOn = 0;
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule